// File: doc/BRIEF.md
# Dual-Path PRBS Test Pattern Inserter

This block makes a serial pseudo-random test sequence and can put it in place of live NRZ data on two independent paths of a DS3/E3 line interface. One path is the transmit path, clocked by the transmit line clock. The other is the receive path, clocked by the receive clock. Each path has its own generator and its own enable. When a path's enable is high, the path outputs the generator's bit instead of its incoming data. When the enable is low, the incoming data passes straight through.

A single length-select input picks the sequence length for both generators: 2^15-1 or 2^23-1. Each generator is a shift register with linear feedback. A generator moves forward by exactly one bit on each rising edge of its own clock while its enable is high. The generator reloads a non-zero seed after reset, and again whenever it sees a new length select on a clock edge. Because of this, it can never settle in the all-zero state.

The enables and the length select are expected to be synchronous to each path's clock. Producing the clocks and encoding the line are handled elsewhere.

Top module: `prbs_test_gen`

## Requirements
- R1: With `long_sel`=0, the enabled output bit stream o[n] follows o[n] = o[n-15] XOR o[n-14] (polynomial x^15+x^14+1, period 32767).
- R2: With `long_sel`=1, the enabled output bit stream follows o[n] = o[n-23] XOR o[n-18] (polynomial x^23+x^18+1).
- R3: While `tx_gen_en`=1, `tx_nrz_out` carries the transmit generator's current bit. While it is 0, `tx_nrz_out` equals `tx_nrz_in` in the same cycle, with no register in between.
- R4: While `rx_gen_en`=1, `rx_nrz_out` carries the receive generator's current bit. While it is 0, `rx_nrz_out` equals `rx_nrz_in` in the same cycle.
- R5: A generator advances by one bit on each rising edge of its own clock on which its enable is 1. On any other edge it holds its state, so the sequence resumes where it stopped.
- R6: A synchronous active-high reset (`tx_rst` or `rx_rst`) loads the seed. The seed is all ones in the stages that are in use, so the first 15 (or 23) output bits after reset are 1. The length is taken from `long_sel` at that edge.
- R7: On a clock edge where `long_sel` differs from the length the generator currently runs, the generator reloads the seed for the new length instead of advancing. This happens whether or not the path is enabled.
- R8: The two paths are independent. Reset, enable, clock and data on one path have no effect on the other path's output or sequence position.
- R9: A generator's shift register is never all zeros outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit line clock |
| tx_rst | input | 1 | Synchronous active-high reset, transmit domain |
| rx_clk | input | 1 | Receive clock |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| long_sel | input | 1 | Sequence length: 0 selects 2^15-1, 1 selects 2^23-1 |
| tx_gen_en | input | 1 | Substitute the pattern on the transmit path |
| rx_gen_en | input | 1 | Substitute the pattern on the receive path |
| tx_nrz_in | input | 1 | Live transmit NRZ data |
| rx_nrz_in | input | 1 | Live receive NRZ data |
| tx_nrz_out | output | 1 | Transmit NRZ data after optional substitution |
| rx_nrz_out | output | 1 | Receive NRZ data after optional substitution |

## Verification
The bench runs the short sequence past a full period of 32767 bits. A wrong tap or a wrong output stage would break the recurrence within a few dozen bits. Enable is dropped in the middle of a run to catch a generator that keeps running, or that restarts, while disabled. The length select is toggled both while a path is enabled and while it is disabled. A design that missed the reload would keep a stale short-register state in long mode, or give a run of ones at the wrong moment. The receive path is reset, and its enable is pulsed, while the transmit path keeps running. Any coupling between the two generators would then show up as a break in the other path's stream.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    parameter int REG_W       = 23;
    parameter int SHORT_ORDER = 15;
    parameter int SHORT_TAP   = 14;
    parameter int LONG_ORDER  = 23;
    parameter int LONG_TAP    = 18;

    typedef enum logic {
        LEN_SHORT = 1'b0,
        LEN_LONG  = 1'b1
    } seq_len_e;

    typedef logic [REG_W-1:0] lfsr_t;

    typedef struct packed {
        lfsr_t    bits;
        seq_len_e len;
    } gen_state_t;

    function automatic int order_of(seq_len_e l);
        return (l == LEN_LONG) ? LONG_ORDER : SHORT_ORDER;
    endfunction

    function automatic int tap_of(seq_len_e l);
        return (l == LEN_LONG) ? LONG_TAP : SHORT_TAP;
    endfunction

    // Ones in the stages the chosen length uses; doubles as the seed.
    function automatic lfsr_t seed_of(seq_len_e l);
        lfsr_t m;
        for (int i = 0; i < REG_W; i++) begin
            m[i] = (i < order_of(l));
        end
        return m;
    endfunction

    function automatic logic out_bit(lfsr_t s, seq_len_e l);
        return s[order_of(l)-1];
    endfunction

    function automatic lfsr_t step(lfsr_t s, seq_len_e l);
        logic fb;
        fb = s[order_of(l)-1] ^ s[tap_of(l)-1];
        return {s[REG_W-2:0], fb} & seed_of(l);
    endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  seq_len_e   len_req,
    output gen_state_t state,
    output logic       pat_bit
);

    logic reload;
    assign reload = rst || (state.len != len_req);

    always_ff @(posedge clk) begin
        if (reload) begin
            state.bits <= seed_of(len_req);
            state.len  <= len_req;
        end else if (advance) begin
            state.bits <= step(state.bits, state.len);
        end
    end

    assign pat_bit = out_bit(state.bits, state.len);

endmodule

// File: rtl/path_mux.sv
module path_mux (
    input  logic sel_pat,
    input  logic live_bit,
    input  logic pat_bit,
    output logic out_bit
);

    assign out_bit = sel_pat ? pat_bit : live_bit;

endmodule

// File: rtl/prbs_lane.sv
module prbs_lane
    import prbs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     gen_en,
    input  seq_len_e len_sel,
    input  logic     nrz_in,
    output logic     nrz_out,
    output lfsr_t    state_bits,
    output seq_len_e state_len
);

    gen_state_t st;
    logic       pbit;

    prbs_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .advance (gen_en),
        .len_req (len_sel),
        .state   (st),
        .pat_bit (pbit)
    );

    path_mux u_mux (
        .sel_pat  (gen_en),
        .live_bit (nrz_in),
        .pat_bit  (pbit),
        .out_bit  (nrz_out)
    );

    assign state_bits = st.bits;
    assign state_len  = st.len;

endmodule

// File: rtl/prbs_test_gen.sv
module prbs_test_gen
    import prbs_pkg::*;
(
    input  logic tx_clk,
    input  logic tx_rst,
    input  logic rx_clk,
    input  logic rx_rst,
    input  logic long_sel,
    input  logic tx_gen_en,
    input  logic rx_gen_en,
    input  logic tx_nrz_in,
    input  logic rx_nrz_in,
    output logic tx_nrz_out,
    output logic rx_nrz_out
);

    localparam int NUM_LANES = 2;
    localparam int TX_LANE   = 0;
    localparam int RX_LANE   = 1;

    logic [NUM_LANES-1:0] lane_clk;
    logic [NUM_LANES-1:0] lane_rst;
    logic [NUM_LANES-1:0] lane_en;
    logic [NUM_LANES-1:0] lane_din;
    logic [NUM_LANES-1:0] lane_dout;
    lfsr_t                lane_bits [NUM_LANES];
    seq_len_e             lane_len  [NUM_LANES];
    seq_len_e             len_sel;

    assign lane_clk = {rx_clk, tx_clk};
    assign lane_rst = {rx_rst, tx_rst};
    assign lane_en  = {rx_gen_en, tx_gen_en};
    assign lane_din = {rx_nrz_in, tx_nrz_in};
    assign len_sel  = seq_len_e'(long_sel);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        prbs_lane u_lane (
            .clk        (lane_clk[g]),
            .rst        (lane_rst[g]),
            .gen_en     (lane_en[g]),
            .len_sel    (len_sel),
            .nrz_in     (lane_din[g]),
            .nrz_out    (lane_dout[g]),
            .state_bits (lane_bits[g]),
            .state_len  (lane_len[g])
        );
    end

    assign tx_nrz_out = lane_dout[TX_LANE];
    assign rx_nrz_out = lane_dout[RX_LANE];

    lfsr_t    tx_state;
    lfsr_t    rx_state;
    seq_len_e tx_len_q;
    seq_len_e rx_len_q;

    assign tx_state = lane_bits[TX_LANE];
    assign rx_state = lane_bits[RX_LANE];
    assign tx_len_q = lane_len[TX_LANE];
    assign rx_len_q = lane_len[RX_LANE];

endmodule

// File: rtl/prbs_test_gen_chk.sv
module prbs_test_gen_chk
    import prbs_pkg::*;
(
    input logic     tx_clk,
    input logic     tx_rst,
    input logic     rx_clk,
    input logic     rx_rst,
    input logic     long_sel,
    input logic     tx_gen_en,
    input logic     rx_gen_en,
    input logic     tx_nrz_in,
    input logic     rx_nrz_in,
    input logic     tx_nrz_out,
    input logic     rx_nrz_out,
    input lfsr_t    tx_state,
    input lfsr_t    rx_state,
    input seq_len_e tx_len_q,
    input seq_len_e rx_len_q
);

    // R3
    tx_pass_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
        !tx_gen_en |-> (tx_nrz_out == tx_nrz_in));

    // R4
    rx_pass_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
        !rx_gen_en |-> (rx_nrz_out == rx_nrz_in));

    // R9
    tx_nonzero_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
        tx_state != '0);

    // R9
    rx_nonzero_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
        rx_state != '0);

    // R5
    tx_hold_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
        (!tx_gen_en && (long_sel == tx_len_q)) |=> $stable(tx_state));

    // R5
    rx_hold_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
        (!rx_gen_en && (long_sel == rx_len_q)) |=> $stable(rx_state));

    // R7
    tx_reload_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
        (long_sel != tx_len_q) |=> (tx_state == seed_of(tx_len_q)));

    // R7
    rx_reload_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
        (long_sel != rx_len_q) |=> (rx_state == seed_of(rx_len_q)));

endmodule

bind prbs_test_gen prbs_test_gen_chk u_chk (.*);

// File: tb/tb_prbs_test_gen.sv
module tb_prbs_test_gen;

    logic tx_clk = 1'b0;
    logic rx_clk = 1'b0;
    logic tx_rst, rx_rst, long_sel;
    logic tx_gen_en, rx_gen_en, tx_nrz_in, rx_nrz_in;
    logic tx_nrz_out, rx_nrz_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit tx_done  = 1'b0;
    bit rx_done  = 1'b0;

    localparam int TX_CYCLES = 36000;

    always #2 tx_clk = ~tx_clk;
    always #3 rx_clk = ~rx_clk;

    prbs_test_gen dut (
        .tx_clk     (tx_clk),
        .tx_rst     (tx_rst),
        .rx_clk     (rx_clk),
        .rx_rst     (rx_rst),
        .long_sel   (long_sel),
        .tx_gen_en  (tx_gen_en),
        .rx_gen_en  (rx_gen_en),
        .tx_nrz_in  (tx_nrz_in),
        .rx_nrz_in  (rx_nrz_in),
        .tx_nrz_out (tx_nrz_out),
        .rx_nrz_out (rx_nrz_out)
    );

    // Behavioural model: the history of emitted pattern bits and the
    // recurrence each length obeys.
    bit tx_hist[$];
    bit rx_hist[$];
    bit tx_mode, rx_mode;

    function automatic bit model_next(input bit h[$], input bit lng);
        int ord = lng ? 23 : 15;
        int tp  = lng ? 18 : 14;
        int n   = h.size();
        if (n < ord) return 1'b1;
        return h[n-ord] ^ h[n-tp];
    endfunction

    task automatic check_bit(input string tag, input logic act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input string lane, input bit en,
                                     input bit lng, input int hsz);
        if (!en) return lane;
        return $sformatf("%s %s R5%s", lane, lng ? "R2" : "R1",
                         (hsz < (lng ? 23 : 15)) ? " R6 R7" : "");
    endfunction

    // Transmit path stimulus, check and model.
    initial begin
        tx_rst = 1'b1; tx_gen_en = 1'b0; tx_nrz_in = 1'b0; long_sel = 1'b0;
        for (int c = 0; c < TX_CYCLES; c++) begin
            @(negedge tx_clk);
            if (c > 0)
                check_bit(tag_of("R3", tx_gen_en, tx_mode, tx_hist.size()),
                          tx_nrz_out,
                          tx_gen_en ? model_next(tx_hist, tx_mode) : bit'(tx_nrz_in));
            tx_rst    = (c < 3) || (c >= 35500 && c < 35503);
            tx_nrz_in = 1'($urandom);
            // R5: pause in mid-sequence, R7: length switched enabled and disabled
            tx_gen_en = !((c >= 40 && c < 60) || (c >= 34000 && c < 34020)
                          || (c >= 35000 && c < 35100));
            long_sel  = (c >= 33000 && c < 35000) || (c >= 35050);
            @(posedge tx_clk);
            if (tx_rst || (long_sel != tx_mode)) begin
                tx_hist.delete();
                tx_mode = long_sel;
            end else if (tx_gen_en) begin
                tx_hist.push_back(model_next(tx_hist, tx_mode));
                if (tx_hist.size() > 32) tx_hist.delete(0);
            end
        end
        tx_done = 1'b1;
    end

    // Receive path: R8, runs its own reset and enable pattern concurrently.
    initial begin
        rx_rst = 1'b1; rx_gen_en = 1'b0; rx_nrz_in = 1'b0;
        for (int c = 0; !tx_done; c++) begin
            @(negedge rx_clk);
            if (c > 0)
                check_bit(tag_of("R4 R8", rx_gen_en, rx_mode, rx_hist.size()),
                          rx_nrz_out,
                          rx_gen_en ? model_next(rx_hist, rx_mode) : bit'(rx_nrz_in));
            rx_rst    = (c < 2) || (c >= 5000 && c < 5003);
            rx_nrz_in = 1'($urandom);
            rx_gen_en = (c % 5 != 0) && !(c >= 2000 && c < 2500);
            @(posedge rx_clk);
            if (rx_rst || (long_sel != rx_mode)) begin
                rx_hist.delete();
                rx_mode = long_sel;
            end else if (rx_gen_en) begin
                rx_hist.push_back(model_next(rx_hist, rx_mode));
                if (rx_hist.size() > 32) rx_hist.delete(0);
            end
        end
        rx_done = 1'b1;
    end

    initial begin
        fork
            wait (tx_done && rx_done);
            begin
                #400000;
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule